// File: doc/BRIEF.md
# Gated Serial ADC Read Controller

This block runs one read transaction with an external serial analog-to-digital converter. The converter has an active-low chip select, a serial clock, a data input, a data output and an end-of-conversion line. A host asks for a conversion by pulsing a start strobe with a 4-bit channel number. The controller then pulls chip select low and holds it for a setup interval. After that it asserts an active-low clock enable and sends twelve cycles of a divided serial clock. During those cycles it shifts the channel word out and shifts in the result of the conversion that was started by the previous transaction.

After the last clock the converter starts the newly requested conversion and pulls end-of-conversion low. The controller waits for that falling edge. If it does not see the edge within the allowed window, it raises an error flag. When the line goes high again, the controller presents the captured word to the host with a single-cycle valid strobe. Requests that arrive while a transaction is running, or while end-of-conversion is low, are dropped.

The serial clock divider and the setup and timeout windows are all derived at elaboration time from the system clock frequency. An elaboration check rejects any setting that would drive the serial clock faster than 4.1 MHz.

Top module: `adc_xfer_ctrl`

## Requirements
- R1: Each high phase and each low phase between serial clock edges lasts at least HALF_DIV system cycles, where HALF_DIV = ceil(CLK_HZ / (2 * 4.1 MHz)). This gives 7 cycles at the default 50 MHz, so the serial clock never runs faster than 4.1 MHz.
- R2: `adc_sclk_o` is low whenever `adc_sclk_en_n_o` is high. The enable is low only while the twelve bit cycles run, and it is high again once chip select returns high.
- R3: `adc_cs_n_o` stays low for at least SETUP_CYC system cycles before the first rising edge of the serial clock, where SETUP_CYC = ceil(1.425 us * CLK_HZ), which is 72 at default. The serial clock is never high while chip select is high.
- R4: A transaction produces exactly 12 rising serial clock edges. At those rising edges `adc_din_o` carries the channel number MSB first in the first 4 bits, followed by 8 zero bits. The data output changes only after falling edges.
- R5: `adc_dout_i` is sampled on each rising serial clock edge, and the 12 samples form `result_o` with the first sample as bit 11.
- R6: After the last serial clock, the controller waits for `adc_eoc_i` to go low and then high. When it sees the line high again, it drives `valid_o` high for exactly one cycle with the captured word on `result_o`.
- R7: If `adc_eoc_i` is not seen low within TMO_CYC = floor(2.2 us * CLK_HZ) cycles of the last serial clock (110 at default), the controller sets `tmo_err_o`, skips the valid strobe and returns to idle. The flag stays high until the next accepted start.
- R8: `busy_o` is high while a transaction or end-of-conversion wait is in progress, and also whenever `adc_eoc_i` is low. A start pulse seen while `busy_o` is high is ignored: chip select does not fall.
- R9: While reset is high, and in the first cycle after it is released, the outputs are: chip select high, clock enable high, serial clock low, data out low, valid low, busy low, error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request strobe |
| chan_i | input | CH_W | Channel number sent with the request |
| busy_o | output | 1 | Request cannot be taken now |
| result_o | output | NBITS | Word read from the converter |
| valid_o | output | 1 | One-cycle strobe marking `result_o` |
| tmo_err_o | output | 1 | End-of-conversion never fell in time |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_sclk_o | output | 1 | Gated serial clock to the converter |
| adc_sclk_en_n_o | output | 1 | Serial clock enable, active low |
| adc_din_o | output | 1 | Serial data to the converter |
| adc_dout_i | input | 1 | Serial data from the converter |
| adc_eoc_i | input | 1 | End-of-conversion from the converter, low while converting |

## Verification
The bench runs transactions against a behavioural converter model. It uses random channel numbers, random delays before end-of-conversion falls, and random conversion lengths. The random runs show that the channel bits, the returned word and the one-cycle strobe stay aligned across widely different timings.

Directed cases cover several situations:
- Channels 0 and 15 expose bit-order and stuck-bit faults.
- A fall delay close to the timeout window separates a correct window length from one that is too short.
- A case where end-of-conversion never falls exercises the error path, and shows that the old conversion word is returned by the following read.
- Start pulses issued while the line is low, both inside a transaction and after a timeout, show whether requests are really refused.

// File: rtl/adc_xfer_pkg.sv
package adc_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_WAIT_LO,
    ST_WAIT_HI
  } xfer_st_t;

  function automatic int ceil_div(input longint num, input longint den);
    return int'((num + den - 1) / den);
  endfunction

  function automatic int floor_div(input longint num, input longint den);
    return int'(num / den);
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
// Divided serial clock; held low and phase-reset while run is low.
module adc_sclk_div #(
  parameter int HALF_DIV = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] hcnt;
  logic          wrap;

  assign wrap   = run && (hcnt == CW'(HALF_DIV - 1));
  assign rise_o = wrap && !sclk_o;
  assign fall_o = wrap && sclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt   <= '0;
      sclk_o <= 1'b0;
    end else if (wrap) begin
      hcnt   <= '0;
      sclk_o <= ~sclk_o;
    end else begin
      hcnt   <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_shift_io.sv
// Transmit/receive shifters and bit counter for one transaction.
module adc_shift_io #(
  parameter int NBITS = 12,
  parameter int CH_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CH_W-1:0]  chan,
  input  logic             rise,
  input  logic             fall,
  input  logic             sdo_i,
  output logic             sdi_o,
  output logic [NBITS-1:0] rx_o,
  output logic             last_o
);
  localparam int BW = $clog2(NBITS + 1);

  logic [NBITS-1:0] tx;
  logic [BW-1:0]    bitcnt;

  assign sdi_o  = tx[NBITS-1];
  assign last_o = fall && (bitcnt == BW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx     <= '0;
      rx_o   <= '0;
      bitcnt <= '0;
    end else if (load) begin
      tx     <= {chan, {(NBITS - CH_W){1'b0}}};
      bitcnt <= '0;
    end else begin
      if (rise) rx_o <= {rx_o[NBITS-2:0], sdo_i};
      if (fall) begin
        tx     <= {tx[NBITS-2:0], 1'b0};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_eoc_mon.sv
// Synchronises end-of-conversion and times the wait for its falling edge.
module adc_eoc_mon #(
  parameter int TMO_CYC = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic eoc_i,
  input  logic arm,
  output logic eoc_s_o,
  output logic tmo_o
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic          meta;
  logic [TW-1:0] cnt;

  assign tmo_o = arm && eoc_s_o && (cnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      meta    <= 1'b1;
      eoc_s_o <= 1'b1;
    end else begin
      meta    <= eoc_i;
      eoc_s_o <= meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !arm)                  cnt <= '0;
    else if (cnt != TW'(TMO_CYC - 1)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/adc_xfer_ctrl.sv
module adc_xfer_ctrl #(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SCLK_MAX_HZ = 4_100_000,
  parameter int SETUP_PS    = 1_425_000,
  parameter int EOC_TMO_PS  = 2_200_000,
  parameter int NBITS       = 12,
  parameter int CH_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic             busy_o,
  output logic [NBITS-1:0] result_o,
  output logic             valid_o,
  output logic             tmo_err_o,
  output logic             adc_cs_n_o,
  output logic             adc_sclk_o,
  output logic             adc_sclk_en_n_o,
  output logic             adc_din_o,
  input  logic             adc_dout_i,
  input  logic             adc_eoc_i
);
  import adc_xfer_pkg::*;

  localparam longint PS_PER_S = 64'd1_000_000_000_000;
  localparam int HALF_DIV  = ceil_div(longint'(CLK_HZ), 2 * longint'(SCLK_MAX_HZ));
  localparam int SETUP_CYC = ceil_div(longint'(SETUP_PS) * longint'(CLK_HZ), PS_PER_S);
  localparam int TMO_CYC   = floor_div(longint'(EOC_TMO_PS) * longint'(CLK_HZ), PS_PER_S);
  localparam int SW        = $clog2(SETUP_CYC + 1);

  generate
    if (CLK_HZ / (2 * HALF_DIV) > SCLK_MAX_HZ) begin : g_bad_rate
      $error("serial clock would exceed its limit");
    end
    if (NBITS <= CH_W) begin : g_bad_width
      $error("transfer must be longer than the channel word");
    end
    if (SETUP_CYC < 1 || TMO_CYC < 4) begin : g_bad_window
      $error("setup or timeout window too short for this clock");
    end
  endgenerate

  xfer_st_t         state;
  logic [SW-1:0]    set_cnt;
  logic             run, rise, fall, last, eoc_s, tmo, accept;
  logic [NBITS-1:0] rx;

  assign run    = ~adc_sclk_en_n_o;
  assign busy_o = (state != ST_IDLE) || !eoc_s;
  assign accept = start_i && !busy_o;

  adc_sclk_div #(.HALF_DIV(HALF_DIV)) div_i (
    .clk(clk), .rst(rst), .run(run),
    .sclk_o(adc_sclk_o), .rise_o(rise), .fall_o(fall)
  );

  adc_shift_io #(.NBITS(NBITS), .CH_W(CH_W)) sio_i (
    .clk(clk), .rst(rst), .load(accept), .chan(chan_i),
    .rise(rise), .fall(fall), .sdo_i(adc_dout_i),
    .sdi_o(adc_din_o), .rx_o(rx), .last_o(last)
  );

  adc_eoc_mon #(.TMO_CYC(TMO_CYC)) eoc_i (
    .clk(clk), .rst(rst), .eoc_i(adc_eoc_i),
    .arm(state == ST_WAIT_LO), .eoc_s_o(eoc_s), .tmo_o(tmo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      set_cnt         <= '0;
      adc_cs_n_o      <= 1'b1;
      adc_sclk_en_n_o <= 1'b1;
      valid_o         <= 1'b0;
      result_o        <= '0;
      tmo_err_o       <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_SETUP;
            adc_cs_n_o <= 1'b0;
            tmo_err_o  <= 1'b0;
            set_cnt    <= '0;
          end
        end
        ST_SETUP: begin
          if (set_cnt == SW'(SETUP_CYC - 1)) begin
            state           <= ST_SHIFT;
            adc_sclk_en_n_o <= 1'b0;
          end else begin
            set_cnt <= set_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last) begin
            state           <= ST_WAIT_LO;
            adc_sclk_en_n_o <= 1'b1;
            adc_cs_n_o      <= 1'b1;
          end
        end
        ST_WAIT_LO: begin
          if (!eoc_s) begin
            state <= ST_WAIT_HI;
          end else if (tmo) begin
            state     <= ST_IDLE;
            tmo_err_o <= 1'b1;
          end
        end
        ST_WAIT_HI: begin
          if (eoc_s) begin
            state    <= ST_IDLE;
            valid_o  <= 1'b1;
            result_o <= rx;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_xfer_chk.sv
module adc_xfer_chk #(
  parameter int HALF_DIV  = 7,
  parameter int SETUP_CYC = 72
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic valid_o,
  input logic tmo_err_o,
  input logic adc_cs_n_o,
  input logic adc_sclk_o,
  input logic adc_sclk_en_n_o
);
  localparam int SAT = 1 << 20;

  int   lvl_len;
  int   cs_low_len;
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_len    <= 0;
      cs_low_len <= 0;
      sclk_prev  <= 1'b0;
    end else begin
      sclk_prev <= adc_sclk_o;
      if (adc_sclk_o != sclk_prev) lvl_len <= 1;
      else if (lvl_len < SAT)      lvl_len <= lvl_len + 1;
      if (adc_cs_n_o)              cs_low_len <= 0;
      else if (cs_low_len < SAT)   cs_low_len <= cs_low_len + 1;
    end
  end

  p_phase_len_r1: assert property (@(posedge clk) disable iff (rst)
    ($rose(adc_sclk_o) || $fell(adc_sclk_o)) |-> lvl_len >= HALF_DIV);

  p_clk_gated_r2: assert property (@(posedge clk) disable iff (rst)
    adc_sclk_en_n_o |-> !adc_sclk_o);

  p_cs_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_sclk_o) |-> cs_low_len >= SETUP_CYC);

  p_clk_needs_cs_r3: assert property (@(posedge clk) disable iff (rst)
    adc_sclk_o |-> !adc_cs_n_o);

  p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_err_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
    tmo_err_o |-> !valid_o);

  p_busy_in_xfer_r8: assert property (@(posedge clk) disable iff (rst)
    !adc_cs_n_o |-> busy_o);
endmodule

bind adc_xfer_ctrl adc_xfer_chk #(
  .HALF_DIV(HALF_DIV),
  .SETUP_CYC(SETUP_CYC)
) chk_i (
  .clk(clk), .rst(rst), .busy_o(busy_o), .valid_o(valid_o),
  .tmo_err_o(tmo_err_o), .adc_cs_n_o(adc_cs_n_o),
  .adc_sclk_o(adc_sclk_o), .adc_sclk_en_n_o(adc_sclk_en_n_o)
);

// File: tb/adc_xfer_ctrl_tb_top.sv
module adc_xfer_ctrl_tb_top;
  localparam int HALF_DIV  = 7;
  localparam int SETUP_CYC = 72;
  localparam int TMO_CYC   = 110;
  localparam int NB        = 12;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
  logic [3:0] chan_i = '0;
  logic busy_o, valid_o, tmo_err_o, adc_cs_n_o, adc_sclk_o, adc_sclk_en_n_o, adc_din_o;
  logic [NB-1:0] result_o;
  logic adc_dout_i, adc_eoc_i = 1'b1;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  adc_xfer_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
    .busy_o(busy_o), .result_o(result_o), .valid_o(valid_o), .tmo_err_o(tmo_err_o),
    .adc_cs_n_o(adc_cs_n_o), .adc_sclk_o(adc_sclk_o), .adc_sclk_en_n_o(adc_sclk_en_n_o),
    .adc_din_o(adc_din_o), .adc_dout_i(adc_dout_i), .adc_eoc_i(adc_eoc_i)
  );

  // converter model: holds the word of its last conversion
  logic [NB-1:0] conv_reg = 12'h5A3;
  logic [NB-1:0] got_din = '0;
  int            fall_cnt = 0;

  always @(negedge adc_sclk_o or posedge adc_cs_n_o)
    if (adc_cs_n_o) fall_cnt <= 0;
    else            fall_cnt <= fall_cnt + 1;

  assign adc_dout_i = (fall_cnt < NB) ? conv_reg[NB-1-fall_cnt] : 1'b0;

  always @(posedge adc_sclk_o) got_din <= {got_din[NB-2:0], adc_din_o};

  function automatic logic [NB-1:0] conv_fn(input logic [3:0] ch, input int k);
    return NB'((int'(ch) * 251) ^ (k * 37) ^ 12'h3C5);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 1000 && busy_o; g++) @(negedge clk);
  endtask

  // one read; no_eoc leaves end-of-conversion high to force a timeout
  task automatic do_xact(input logic [3:0] ch, input int fall_dly, input int low_len,
                         input bit no_eoc, input int k);
    int rises = 0, min_ph = 1000, ph = 0, setup_lo = 0, gate_bad = 0, vcnt = 0;
    logic prev = 1'b0;
    logic [NB-1:0] exp_res;
    exp_res = conv_reg;
    wait_idle();
    @(negedge clk); start_i = 1'b1; chan_i = ch;
    @(negedge clk); start_i = 1'b0;
    check(adc_cs_n_o == 1'b0, "R8", "start accepted when idle", adc_cs_n_o, 0);
    check(tmo_err_o == 1'b0, "R7", "error cleared by start", tmo_err_o, 0);
    for (int g = 0; g < 3000 && !adc_cs_n_o; g++) begin
      if (adc_sclk_en_n_o && adc_sclk_o) gate_bad++;
      if (!adc_sclk_o && rises == 0) setup_lo++;
      if (adc_sclk_o != prev) begin
        if (prev || rises > 0) min_ph = (ph < min_ph) ? ph : min_ph;
        if (adc_sclk_o) rises++;
        ph = 1;
      end else ph++;
      prev = adc_sclk_o;
      @(negedge clk);
    end
    check(min_ph >= HALF_DIV, "R1", "shortest clock phase", min_ph, HALF_DIV);
    check(gate_bad == 0 && adc_sclk_en_n_o && !adc_sclk_o, "R2",
          "clock gated by enable", gate_bad, 0);
    check(setup_lo >= SETUP_CYC, "R3", "select-to-clock setup", setup_lo, SETUP_CYC);
    check(rises == NB, "R4", "rising clock count", rises, NB);
    check(got_din == {ch, 8'h00}, "R4", "channel word on din", got_din, {ch, 8'h00});
    check(busy_o == 1'b1, "R8", "busy during eoc wait", busy_o, 1);
    if (no_eoc) begin
      for (int i = 0; i < TMO_CYC + 10; i++) begin
        if (valid_o) vcnt++;
        @(negedge clk);
      end
      check(tmo_err_o == 1'b1 && vcnt == 0, "R7", "timeout flag", tmo_err_o, 1);
      check(busy_o == 1'b0, "R8", "idle after timeout", busy_o, 0);
    end else begin
      for (int i = 1; i < fall_dly; i++) @(negedge clk);
      adc_eoc_i = 1'b0;
      conv_reg  = conv_fn(ch, k);
      for (int i = 0; i < low_len; i++) begin
        if (valid_o) vcnt++;
        start_i = (i == low_len / 2);
        chan_i  = ~ch;
        @(negedge clk);
      end
      start_i = 1'b0;
      check(adc_cs_n_o && busy_o && vcnt == 0, "R8", "start refused while eoc low",
            adc_cs_n_o, 1);
      adc_eoc_i = 1'b1;
      for (int i = 0; i < 12; i++) begin
        if (valid_o) begin
          vcnt++;
          check(result_o == exp_res, "R5", "result word", result_o, exp_res);
        end
        @(negedge clk);
      end
      check(vcnt == 1, "R6", "valid pulse count", vcnt, 1);
      check(tmo_err_o == 1'b0 && adc_cs_n_o, "R7", "no error on normal read",
            tmo_err_o, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(adc_cs_n_o && adc_sclk_en_n_o && !adc_sclk_o && !adc_din_o && !valid_o
          && !busy_o && !tmo_err_o, "R9", "outputs in reset", adc_cs_n_o, 1);
    rst = 1'b0;
    @(negedge clk);
    check(adc_cs_n_o && adc_sclk_en_n_o && !adc_sclk_o && !valid_o && !busy_o,
          "R9", "outputs after reset", busy_o, 0);

    do_xact(4'h0, 1, 5, 1'b0, 1);
    do_xact(4'hF, 100, 80, 1'b0, 2);
    do_xact(4'h9, 0, 0, 1'b1, 3);
    // late eoc after timeout: still refuses, gives no strobe, keeps flag
    adc_eoc_i = 1'b0;
    repeat (5) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    check(adc_cs_n_o && busy_o, "R8", "start refused while idle eoc low", adc_cs_n_o, 1);
    adc_eoc_i = 1'b1;
    begin
      int v = 0;
      for (int i = 0; i < 8; i++) begin if (valid_o) v++; @(negedge clk); end
      check(v == 0 && tmo_err_o, "R7", "flag held, no strobe after late eoc", v, 0);
    end
    do_xact(4'h6, 20, 10, 1'b0, 4);
    for (int n = 0; n < 20; n++)
      do_xact(4'($urandom_range(15)), int'($urandom_range(1, 90)),
              int'($urandom_range(5, 80)), 1'b0, 10 + n);
    summary();
    $finish;
  end
endmodule